// File: doc/BRIEF.md
# Packet-Driven Local Bus Master

This block sits behind a serial packet decoder that has already picked out the packets meant for this unit. It receives the decoder's local byte stream: a start strobe on the first byte of a packet, a byte with a valid strobe, and a stop strobe that marks the end of the packet. Packets aimed at sub-unit 0 with a known command are turned into 32-bit cycles on a simple parallel local bus. The bus has an address, write data, read data, a write strobe, a read strobe and an acknowledge.

The first four payload bytes give the start address. For write commands, every further group of four bytes is one data word. For read commands, the next four bytes give a word count. The command picks between an incrementing address (step 4) and a fixed address. Read words are sent back one byte per cycle, most significant byte first, for an upstream transmitter that frames the reply.

The byte stream has no backpressure. An acknowledge for each write has to arrive before the next data word is complete: with one payload byte every few cycles, that gives about four byte times.

Top module: `pkt_lbus_master`

## Requirements
- R1: While reset is high and in the first cycle after it, `lb_wr`, `lb_rd` and `out_valid` are low.
- R2: A packet is acted on only when all of the following hold:
  - Its first byte (the one that comes with `in_start`) is 0xF0.
  - The high nibble of its third byte (the sub-unit) is 0x0.
  - The low nibble of its third byte (the command) is 0x0 to 0x3.

  The second byte (routing) and the fourth byte (length) have no effect. A packet that fails any of these tests causes no bus cycle and no output byte.
- R3: Command 0x0 (incrementing write) works as follows:
  - Payload bytes 1 to 4 give the address A, most significant byte first.
  - Each following group of four bytes is a data word, most significant byte first.
  - Word k is written to address A+4k, with the address wrapping modulo 2^32.
- R4: `lb_wr` rises in the cycle right after the cycle that presents the fourth byte of a data word. In that same cycle `lb_addr` and `lb_wdata` carry that word's address and data.
- R5: A write or read strobe stays high until `lb_ack` is sampled high. `lb_addr` and `lb_wdata` hold steady while the strobe is high, and the strobe is low in the following cycle. With an acknowledge that arrives L cycles after the strobe is first seen, the strobe is high for L+2 cycles.
- R6: Command 0x2 (fixed write) writes every data word to address A.
- R7: Command 0x1 (incrementing read) works as follows:
  - Payload bytes 5 to 8 give a count N, most significant byte first.
  - N reads are made, from A, A+4 and so on.
  - Each read word appears on `out_byte` as four bytes, most significant byte first, with `out_valid` high. The bytes come in the four cycles right after the clock edge that samples `lb_ack`.
- R8: Command 0x3 (fixed read) makes all N reads from address A.
- R9: A read count of zero makes no read cycle and no output byte.
- R10: If `in_stop` arrives while a 4-byte group is only partly received, that group is dropped and makes no cycle. Bytes that arrive after a stop without a new `in_start` are ignored.
- R11: The next read is not issued until all four bytes of the previous read word have been sent. `out_valid` is never high while `lb_rd` is high. `lb_wr` and `lb_rd` are never high together.
- R12: In a read packet, payload bytes after the count have no effect.

A new `in_start` cancels any reads that have not yet been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_start | input | 1 | Marks the first byte of a packet |
| in_valid | input | 1 | `in_byte` is valid this cycle |
| in_byte | input | 8 | Packet byte |
| in_stop | input | 1 | End of packet; may come with the last byte |
| lb_addr | output | ADDR_W | Local bus address |
| lb_wdata | output | DATA_W | Local bus write data |
| lb_wr | output | 1 | Write strobe, held until acknowledged |
| lb_rd | output | 1 | Read strobe, held until acknowledged |
| lb_rdata | input | DATA_W | Local bus read data, taken with `lb_ack` |
| lb_ack | input | 1 | Cycle acknowledge |
| out_valid | output | 1 | `out_byte` carries a read data byte |
| out_byte | output | 8 | Read data byte, most significant byte first |

## Verification
A write strobe is due one cycle after the fourth data byte. It lasts exactly two cycles more than the acknowledge latency of the bench's bus model. The four read bytes occupy the four cycles after the edge that samples the acknowledge. The bench drives inputs on falling edges and checks the write strobe at the falling edges on either side of the edge that takes the fourth byte. It stamps every output byte with its clock count and compares that count with the edge that sampled the acknowledge, so a byte that comes late or early shows up even when its value is correct.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

   localparam int unsigned BYTE_W = 8;

   // packet progress as seen by the bus control
   typedef enum logic [1:0] {
      PH_IDLE,
      PH_ADDR,
      PH_BODY,
      PH_SKIP
   } phase_e;

   // decoded command: read or write, fixed or incrementing address
   typedef struct packed {
      logic is_rd;
      logic fixed;
   } op_t;

   function automatic logic cmd_known(input logic [3:0] c);
      return (c[3:2] == 2'b00);
   endfunction

endpackage

// File: rtl/lbm_hdr.sv
module lbm_hdr
   import lbm_pkg::*;
#(
   parameter logic [7:0] LEAD_BYTE = 8'hF0,
   parameter logic [3:0] UNIT_ID   = 4'h0
)(
   input  logic       clk,
   input  logic       rst,
   input  logic       in_start,
   input  logic       in_valid,
   input  logic [7:0] in_byte,
   input  logic       in_stop,
   output logic       pay_valid,
   output op_t        op
);

   localparam int unsigned IDX_W = 3;
   localparam logic [IDX_W-1:0] IDX_SEL = IDX_W'(2);
   localparam logic [IDX_W-1:0] IDX_PAY = IDX_W'(4);

   logic             active_q, ok_q;
   logic [IDX_W-1:0] idx_q;
   op_t              op_q;

   logic             act_c, ok_c, take_c;
   logic [IDX_W-1:0] idx_c;

   always_comb begin
      act_c     = in_start | active_q;
      idx_c     = in_start ? '0 : idx_q;
      ok_c      = in_start ? 1'b1 : ok_q;
      take_c    = act_c & in_valid;
      pay_valid = take_c && (idx_c == IDX_PAY) && ok_c;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         ok_q     <= 1'b0;
         op_q     <= '0;
      end else begin
         active_q <= act_c & ~in_stop;
         idx_q    <= idx_c;
         ok_q     <= ok_c;
         if (take_c && (idx_c != IDX_PAY)) begin
            idx_q <= idx_c + IDX_W'(1);
            if ((idx_c == '0) && (in_byte != LEAD_BYTE))
               ok_q <= 1'b0;
            if (idx_c == IDX_SEL) begin
               if ((in_byte[7:4] != UNIT_ID) || !cmd_known(in_byte[3:0]))
                  ok_q <= 1'b0;
               op_q.is_rd <= in_byte[0];
               op_q.fixed <= in_byte[1];
            end
         end
      end
   end

   assign op = op_q;

endmodule

// File: rtl/lbm_word_asm.sv
module lbm_word_asm
   import lbm_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter bit          MSB_FIRST = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              byte_valid,
   input  logic [7:0]        byte_in,
   output logic              word_stb,
   output logic [DATA_W-1:0] word,
   output logic              partial_next
);

   localparam int unsigned NB    = DATA_W / BYTE_W;
   localparam int unsigned CNT_W = $clog2(NB);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(NB - 1);

   logic [DATA_W-BYTE_W-1:0] hold_q, hold_n;
   logic [CNT_W-1:0]         cnt_q, cnt_c;

   generate
      if (MSB_FIRST) begin : g_msb
         assign word   = {hold_q, byte_in};
         assign hold_n = word[DATA_W-BYTE_W-1:0];
      end else begin : g_lsb
         assign word   = {byte_in, hold_q};
         assign hold_n = word[DATA_W-1:BYTE_W];
      end
   endgenerate

   always_comb begin
      word_stb = byte_valid && (cnt_q == LAST);
      cnt_c    = cnt_q;
      if (byte_valid)
         cnt_c = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
      partial_next = (cnt_c != '0);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         hold_q <= '0;
      end else begin
         cnt_q <= clr ? '0 : cnt_c;
         if (byte_valid)
            hold_q <= hold_n;
      end
   end

endmodule

// File: rtl/lbm_rd_ser.sv
module lbm_rd_ser
   import lbm_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter bit          MSB_FIRST = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] word_in,
   output logic              out_valid,
   output logic [7:0]        out_byte,
   output logic              busy
);

   localparam int unsigned NB   = DATA_W / BYTE_W;
   localparam int unsigned LW   = $clog2(NB + 1);
   localparam logic [LW-1:0] FULL = LW'(NB);

   logic [DATA_W-1:0] sh_q, sh_n;
   logic [LW-1:0]     left_q;

   generate
      if (MSB_FIRST) begin : g_msb
         assign out_byte = sh_q[DATA_W-1 -: BYTE_W];
         assign sh_n     = {sh_q[DATA_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
      end else begin : g_lsb
         assign out_byte = sh_q[BYTE_W-1:0];
         assign sh_n     = {{BYTE_W{1'b0}}, sh_q[DATA_W-1:BYTE_W]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (load) begin
         sh_q   <= word_in;
         left_q <= FULL;
      end else if (left_q != '0) begin
         sh_q   <= sh_n;
         left_q <= left_q - LW'(1);
      end
   end

   assign out_valid = (left_q != '0);
   assign busy      = out_valid;

endmodule

// File: rtl/pkt_lbus_master.sv
module pkt_lbus_master
   import lbm_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned ADDR_STEP = 4,
   parameter bit          MSB_FIRST = 1'b1,
   parameter logic [7:0]  LEAD_BYTE = 8'hF0,
   parameter logic [3:0]  UNIT_ID   = 4'h0
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              in_start,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   input  logic              in_stop,
   output logic [ADDR_W-1:0] lb_addr,
   output logic [DATA_W-1:0] lb_wdata,
   output logic              lb_wr,
   output logic              lb_rd,
   input  logic [DATA_W-1:0] lb_rdata,
   input  logic              lb_ack,
   output logic              out_valid,
   output logic [7:0]        out_byte
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ADDR_STEP);

   generate
      if ((DATA_W % BYTE_W) != 0 || (DATA_W / BYTE_W) < 2) begin : g_bad_data
         $error("DATA_W must be a multiple of 8 and hold at least two bytes");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("ADDR_W must not exceed DATA_W");
      end
      if (CNT_W > DATA_W || CNT_W == 0) begin : g_bad_cnt
         $error("CNT_W must lie in 1..DATA_W");
      end
   endgenerate

   logic              pay_valid;
   op_t               op;
   logic              word_stb, partial_next;
   logic [DATA_W-1:0] word;
   logic              ser_busy;

   phase_e            phase_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  rd_left_q;
   logic [ADDR_W-1:0] step_c;
   logic              rd_go;

   lbm_hdr #(
      .LEAD_BYTE (LEAD_BYTE),
      .UNIT_ID   (UNIT_ID)
   ) u_hdr (
      .clk       (clk),
      .rst       (rst),
      .in_start  (in_start),
      .in_valid  (in_valid),
      .in_byte   (in_byte),
      .in_stop   (in_stop),
      .pay_valid (pay_valid),
      .op        (op)
   );

   lbm_word_asm #(
      .DATA_W    (DATA_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_asm (
      .clk          (clk),
      .rst          (rst),
      .clr          (in_start | in_stop),
      .byte_valid   (pay_valid),
      .byte_in      (in_byte),
      .word_stb     (word_stb),
      .word         (word),
      .partial_next (partial_next)
   );

   lbm_rd_ser #(
      .DATA_W    (DATA_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_ser (
      .clk       (clk),
      .rst       (rst),
      .load      (lb_rd & lb_ack),
      .word_in   (lb_rdata),
      .out_valid (out_valid),
      .out_byte  (out_byte),
      .busy      (ser_busy)
   );

   always_comb begin
      step_c = op.fixed ? '0 : STEP;
      rd_go  = !lb_rd && !lb_wr && (rd_left_q != '0) && !ser_busy;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q   <= PH_IDLE;
         addr_q    <= '0;
         rd_left_q <= '0;
         lb_addr   <= '0;
         lb_wdata  <= '0;
         lb_wr     <= 1'b0;
         lb_rd     <= 1'b0;
      end else begin
         if (lb_wr && lb_ack) lb_wr <= 1'b0;
         if (lb_rd && lb_ack) lb_rd <= 1'b0;

         if (rd_go) begin
            lb_rd     <= 1'b1;
            lb_addr   <= addr_q;
            addr_q    <= addr_q + step_c;
            rd_left_q <= rd_left_q - CNT_W'(1);
         end

         if (word_stb) begin
            unique case (phase_q)
               PH_ADDR: begin
                  addr_q  <= word[ADDR_W-1:0];
                  phase_q <= PH_BODY;
               end
               PH_BODY: begin
                  if (op.is_rd) begin
                     rd_left_q <= word[CNT_W-1:0];
                     phase_q   <= PH_SKIP;
                  end else begin
                     lb_wr    <= 1'b1;
                     lb_addr  <= addr_q;
                     lb_wdata <= word;
                     addr_q   <= addr_q + step_c;
                  end
               end
               default: ;
            endcase
         end

         if (in_start) begin
            phase_q   <= PH_ADDR;
            rd_left_q <= '0;
         end
         if (in_stop)
            phase_q <= PH_IDLE;
      end
   end

endmodule

// File: rtl/lbm_chk.sv
module lbm_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
)(
   input logic              clk,
   input logic              rst,
   input logic              lb_wr,
   input logic              lb_rd,
   input logic              lb_ack,
   input logic [ADDR_W-1:0] lb_addr,
   input logic [DATA_W-1:0] lb_wdata,
   input logic              out_valid,
   input logic              word_stb
);

   // R5
   wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (lb_wr && !lb_ack) |=> (lb_wr && $stable(lb_addr) && $stable(lb_wdata)));

   // R5
   wr_release_chk: assert property (@(posedge clk) disable iff (rst)
      (lb_wr && lb_ack && !word_stb) |=> !lb_wr);

   // R5
   rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (lb_rd && !lb_ack) |=> (lb_rd && $stable(lb_addr)));

   // R7
   rd_to_byte_chk: assert property (@(posedge clk) disable iff (rst)
      (lb_rd && lb_ack) |=> (out_valid && !lb_rd));

   // R11
   strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(lb_wr && lb_rd));

   // R11
   ser_excl_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !lb_rd);

endmodule

bind pkt_lbus_master lbm_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .lb_wr     (lb_wr),
   .lb_rd     (lb_rd),
   .lb_ack    (lb_ack),
   .lb_addr   (lb_addr),
   .lb_wdata  (lb_wdata),
   .out_valid (out_valid),
   .word_stb  (word_stb)
);

// File: tb/pkt_lbus_master_tb.sv
module pkt_lbus_master_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_start = 1'b0, in_valid = 1'b0, in_stop = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic [31:0] lb_addr, lb_wdata, lb_rdata;
   logic        lb_wr, lb_rd, out_valid;
   logic        lb_ack;
   logic [7:0]  out_byte;

   always #10 clk = ~clk;

   pkt_lbus_master u_dut (
      .clk (clk), .rst (rst),
      .in_start (in_start), .in_valid (in_valid), .in_byte (in_byte), .in_stop (in_stop),
      .lb_addr (lb_addr), .lb_wdata (lb_wdata), .lb_wr (lb_wr), .lb_rd (lb_rd),
      .lb_rdata (lb_rdata), .lb_ack (lb_ack),
      .out_valid (out_valid), .out_byte (out_byte)
   );

   function automatic logic [31:0] rd_val(input logic [31:0] a);
      return {a[15:0] ^ 16'hA5A5, a[15:0]};
   endfunction

   function automatic logic [31:0] wr_val(input int i);
      return 32'hC0DE_0000 + 32'(i) * 32'h0001_0203;
   endfunction

   assign lb_rdata = rd_val(lb_addr);

   // bus model: acknowledge ack_lat cycles after a strobe is first seen
   int ack_lat = 0;
   int wait_n  = 0;
   always @(posedge clk) begin
      if (rst) begin
         lb_ack <= 1'b0;
         wait_n <= 0;
      end else if (lb_ack) begin
         lb_ack <= 1'b0;
         wait_n <= 0;
      end else if (lb_wr || lb_rd) begin
         if (wait_n >= ack_lat) lb_ack <= 1'b1;
         else                   wait_n <= wait_n + 1;
      end
   end

   // logging
   logic [31:0] wr_a [256];
   logic [31:0] wr_d [256];
   logic [31:0] rd_a [256];
   logic [7:0]  ob   [256];
   int wr_n = 0, rd_n = 0, ob_n = 0, cyc = 0, ack_cyc = 0, bidx = 0;
   int gap_bad = 0, both_bad = 0, ovl_bad = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (lb_wr && lb_ack) begin
         wr_a[wr_n & 255] <= lb_addr;
         wr_d[wr_n & 255] <= lb_wdata;
         wr_n <= wr_n + 1;
      end
      if (lb_rd && lb_ack) begin
         rd_a[rd_n & 255] <= lb_addr;
         rd_n    <= rd_n + 1;
         ack_cyc <= cyc;
         bidx    <= 0;
      end
      if (out_valid) begin
         ob[ob_n & 255] <= out_byte;
         ob_n <= ob_n + 1;
         if (cyc != ack_cyc + 1 + bidx) gap_bad <= gap_bad + 1;
         bidx <= bidx + 1;
      end
      if (lb_wr && lb_rd) both_bad <= both_bad + 1;
      if (out_valid && lb_rd) ovl_bad <= ovl_bad + 1;
   end

   int checks = 0, errs = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b, input bit s, input bit e);
      @(negedge clk);
      in_valid = 1'b1; in_byte = b; in_start = s; in_stop = e;
      @(negedge clk);
      in_valid = 1'b0; in_start = 1'b0; in_stop = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_pkt(input logic [7:0] lead, input logic [7:0] sel,
                           input logic [31:0] addr, input int nw,
                           input bit rdf, input bit extra);
      logic [7:0] bq [80];
      int n;
      int len;
      len = rdf ? (8 + (extra ? 4 : 0)) : (4 + 4 * nw);
      n = 0;
      bq[n] = lead; n++;
      bq[n] = 8'h00; n++;
      bq[n] = sel; n++;
      bq[n] = 8'(len); n++;
      for (int k = 0; k < 4; k++) begin bq[n] = addr[31-8*k -: 8]; n++; end
      if (rdf) begin
         for (int k = 0; k < 4; k++) begin bq[n] = 32'(nw) >> (24 - 8*k); n++; end
         if (extra)
            for (int k = 0; k < 4; k++) begin bq[n] = 8'hAA + 8'(k); n++; end
      end else begin
         for (int i = 0; i < nw; i++)
            for (int k = 0; k < 4; k++) begin
               bq[n] = wr_val(i) >> (24 - 8*k); n++;
            end
      end
      for (int k = 0; k < n; k++) put(bq[k], k == 0, k == n - 1);
   endtask

   typedef struct packed {
      logic [7:0]  lead;
      logic [7:0]  sel;
      logic [31:0] addr;
      logic [7:0]  nw;
      logic [7:0]  lat;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{8'hF0, 8'h00, 32'h0000_0100, 8'd3, 8'd0},
      '{8'hF0, 8'h02, 32'h0000_0040, 8'd3, 8'd2},
      '{8'hF0, 8'h01, 32'h0000_0200, 8'd2, 8'd1},
      '{8'hF0, 8'h03, 32'h0000_0080, 8'd3, 8'd3},
      '{8'hF0, 8'h01, 32'h0000_0010, 8'd0, 8'd1},
      '{8'hF0, 8'h10, 32'h0000_0300, 8'd2, 8'd0},
      '{8'hF0, 8'h05, 32'h0000_0300, 8'd2, 8'd0},
      '{8'hE0, 8'h00, 32'h0000_0300, 8'd2, 8'd0},
      '{8'hF0, 8'h00, 32'hFFFF_FFF8, 8'd3, 8'd1}
   };

   task automatic run_vec(input vec_t t);
      bit acc, rdf, fix;
      int w0, r0, o0, ew, er, nw;
      string rq;
      logic [31:0] ea;
      nw  = int'(t.nw);
      acc = (t.lead == 8'hF0) && (t.sel[7:4] == 4'h0) && (t.sel[3:2] == 2'b00);
      rdf = t.sel[0];
      fix = t.sel[1];
      ack_lat = int'(t.lat);
      w0 = wr_n; r0 = rd_n; o0 = ob_n;
      send_pkt(t.lead, t.sel, t.addr, nw, rdf, 1'b0);
      repeat (30 * nw + 40) @(negedge clk);
      ew = (acc && !rdf) ? nw : 0;
      er = (acc && rdf) ? nw : 0;
      if (!acc)                rq = "R2";
      else if (rdf && nw == 0) rq = "R9";
      else if (rdf)            rq = fix ? "R8" : "R7";
      else                     rq = fix ? "R6" : "R3";
      chk(wr_n - w0 == ew, rq, "write count", 64'(wr_n - w0), 64'(ew));
      chk(rd_n - r0 == er, rq, "read count", 64'(rd_n - r0), 64'(er));
      chk(ob_n - o0 == 4 * er, rq, "out byte count", 64'(ob_n - o0), 64'(4 * er));
      for (int i = 0; i < ew; i++) begin
         ea = t.addr + (fix ? 32'd0 : 32'(4 * i));
         chk(wr_a[(w0 + i) & 255] == ea, rq, "write addr", 64'(wr_a[(w0 + i) & 255]), 64'(ea));
         chk(wr_d[(w0 + i) & 255] == wr_val(i), rq, "write data",
             64'(wr_d[(w0 + i) & 255]), 64'(wr_val(i)));
      end
      for (int i = 0; i < er; i++) begin
         ea = t.addr + (fix ? 32'd0 : 32'(4 * i));
         chk(rd_a[(r0 + i) & 255] == ea, rq, "read addr", 64'(rd_a[(r0 + i) & 255]), 64'(ea));
         for (int k = 0; k < 4; k++)
            chk(ob[(o0 + 4*i + k) & 255] == rd_val(ea)[31-8*k -: 8], rq, "read byte",
                64'(ob[(o0 + 4*i + k) & 255]), 64'(rd_val(ea)[31-8*k -: 8]));
      end
   endtask

   initial begin
      int w0, r0, o0, hi, stab_bad;
      repeat (4) @(negedge clk);
      chk(!lb_wr && !lb_rd && !out_valid, "R1", "outputs in reset",
          64'({lb_wr, lb_rd, out_valid}), 64'd0);
      rst = 1'b0;
      @(negedge clk);
      chk(!lb_wr && !lb_rd && !out_valid, "R1", "outputs after reset",
          64'({lb_wr, lb_rd, out_valid}), 64'd0);

      for (int v = 0; v < NV; v++) run_vec(VEC[v]);

      // R4 / R5: strobe timing and hold
      ack_lat = 4;
      w0 = wr_n;
      put(8'hF0, 1'b1, 1'b0); put(8'h00, 1'b0, 1'b0);
      put(8'h00, 1'b0, 1'b0); put(8'h08, 1'b0, 1'b0);
      put(8'h00, 1'b0, 1'b0); put(8'h00, 1'b0, 1'b0);
      put(8'h05, 1'b0, 1'b0); put(8'h00, 1'b0, 1'b0);
      put(8'h12, 1'b0, 1'b0); put(8'h34, 1'b0, 1'b0); put(8'h56, 1'b0, 1'b0);
      @(negedge clk);
      in_valid = 1'b1; in_byte = 8'h78;
      chk(!lb_wr, "R4", "strobe before 4th byte taken", 64'(lb_wr), 64'd0);
      @(negedge clk);
      in_valid = 1'b0;
      chk(lb_wr, "R4", "strobe after 4th byte", 64'(lb_wr), 64'd1);
      chk(lb_addr == 32'h500, "R4", "write addr", 64'(lb_addr), 64'h500);
      chk(lb_wdata == 32'h1234_5678, "R4", "write data", 64'(lb_wdata), 64'h1234_5678);
      hi = 1; stab_bad = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (lb_wr) begin
            hi++;
            if (lb_addr != 32'h500 || lb_wdata != 32'h1234_5678) stab_bad++;
         end
      end
      chk(hi == ack_lat + 2, "R5", "strobe width", 64'(hi), 64'(ack_lat + 2));
      chk(stab_bad == 0, "R5", "addr/data stable", 64'(stab_bad), 64'd0);
      @(negedge clk); in_stop = 1'b1;
      @(negedge clk); in_stop = 1'b0;
      repeat (5) @(negedge clk);
      chk(wr_n - w0 == 1, "R5", "single write", 64'(wr_n - w0), 64'd1);

      // R10: stop in a partial word, then stray bytes
      ack_lat = 1;
      w0 = wr_n; o0 = ob_n;
      put(8'hF0, 1'b1, 1'b0); put(8'h00, 1'b0, 1'b0);
      put(8'h00, 1'b0, 1'b0); put(8'h08, 1'b0, 1'b0);
      put(8'h00, 1'b0, 1'b0); put(8'h00, 1'b0, 1'b0);
      put(8'h06, 1'b0, 1'b0); put(8'h00, 1'b0, 1'b0);
      put(8'hAA, 1'b0, 1'b0); put(8'hBB, 1'b0, 1'b1);
      repeat (40) @(negedge clk);
      chk(wr_n - w0 == 0, "R10", "partial word dropped", 64'(wr_n - w0), 64'd0);
      for (int k = 0; k < 8; k++) put(8'(k + 1), 1'b0, 1'b0);
      repeat (40) @(negedge clk);
      chk(wr_n - w0 == 0, "R10", "stray bytes ignored", 64'(wr_n - w0), 64'd0);
      chk(ob_n - o0 == 0, "R10", "no output bytes", 64'(ob_n - o0), 64'd0);
      send_pkt(8'hF0, 8'h00, 32'h20, 1, 1'b0, 1'b0);
      repeat (40) @(negedge clk);
      chk(wr_n - w0 == 1, "R10", "recovery write", 64'(wr_n - w0), 64'd1);
      chk(wr_a[w0 & 255] == 32'h20, "R10", "recovery addr", 64'(wr_a[w0 & 255]), 64'h20);

      // R12: extra payload after read count
      ack_lat = 2;
      w0 = wr_n; r0 = rd_n; o0 = ob_n;
      send_pkt(8'hF0, 8'h01, 32'h300, 2, 1'b1, 1'b1);
      repeat (100) @(negedge clk);
      chk(wr_n - w0 == 0, "R12", "no writes from extra bytes", 64'(wr_n - w0), 64'd0);
      chk(rd_n - r0 == 2, "R12", "read count kept", 64'(rd_n - r0), 64'd2);
      chk(ob_n - o0 == 8, "R12", "output bytes", 64'(ob_n - o0), 64'd8);
      chk(rd_a[(r0 + 1) & 255] == 32'h304, "R12", "second read addr",
          64'(rd_a[(r0 + 1) & 255]), 64'h304);

      chk(gap_bad == 0, "R7", "read byte timing", 64'(gap_bad), 64'd0);
      chk(both_bad == 0, "R11", "strobes together", 64'(both_bad), 64'd0);
      chk(ovl_bad == 0, "R11", "output during read", 64'(ovl_bad), 64'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks + 1, errs + 1);
      $finish;
   end

endmodule